// File: doc/BRIEF.md
# Shared Debug Event Ownership Controller

This block decides, for every debug resource, whether an external hardware debugger or on-chip software debug handles it. It holds an event enable mask, an event status register, a per-resource ownership mask and three control bits: external debug mode, interrupt debug mode and sharing enable. Event pulses set status bits. Each set status bit then raises a debug interrupt toward the exception logic or requests entry into debug mode. Which of the two it does depends on who owns the resource.

Software and the debugger each have their own register port. The debugger port sees and changes everything. The software port is filtered by ownership, so software can neither observe nor disturb resources held by hardware. A hardware-owned event and a software interrupt can be due at the same moment. In that case the block lets the exception logic save context first, and only then asks for debug mode.

Effective hardware ownership follows three cases:
- External debug mode off: no resource is owned by hardware.
- External debug mode on, sharing off: every resource is owned by hardware.
- External debug mode on, sharing on: the ownership mask decides, with bit i = 1 meaning resource i is owned by hardware.

Register map, used by both ports (`addr` value and contents):
- 0, control: bit0 = external debug mode, bit1 = interrupt debug mode, bit2 = sharing enable.
- 1, event enable.
- 2, status.
- 3, ownership.

Top module: `dbg_share_ctrl`

## Requirements
- R1: In the cycle after a clock edge where `evt_i[i]` and enable bit i are both 1, status bit i is 1. This holds whatever `sw_de_i` is. It also holds if either port writes a 1 to clear bit i at that same edge.
- R2: `irq_o` is 1 exactly when three things hold: some status bit is set that is not effectively hardware-owned, `sw_de_i` is 1, and the interrupt debug mode bit is 1.
- R3: A hardware-owned event with no software interrupt due makes `dbgreq_o` 1 in the cycle after the event edge. That event alone never raises `irq_o`.
- R4: Once `dbgreq_o` is 1, it stays 1 until `dbgack_i` is sampled high. It is 0 in the cycle after that edge.
- R5: A software interrupt can be due at the edge where a hardware-owned event is recorded, because a software-owned event arrives at that edge or was already pending. In that case `dbgreq_o` stays 0 until `save_done_i` is sampled high, and becomes 1 in the cycle after that edge.
- R6: The software port cannot change the ownership mask, the external debug mode bit or the sharing enable bit.
- R7: While sharing is active, software writes to enable and status change only software-owned bits. Software reads of status return 0 in every hardware-owned bit.
- R8: With external debug mode on and sharing off, all resources act as hardware-owned. Their events request debug mode. Software sees none of their status and can clear none of it.
- R9: With external debug mode off, all resources act as software-owned, and `dbgreq_o` is never 1.
- R10: The debugger port reads and writes every field without masking. Debugger writes to control, enable and ownership override a software write in the same cycle.
- R11: Status bits clear when a 1 is written to them (write-one-to-clear) from either port, subject to R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we_i | input | 1 | Software port write strobe |
| sw_addr_i | input | 2 | Software port register select |
| sw_wdata_i | input | NRES | Software port write data |
| sw_rdata_o | output | NRES | Software port read data (combinational, masked by ownership) |
| dbg_we_i | input | 1 | Debugger port write strobe |
| dbg_addr_i | input | 2 | Debugger port register select |
| dbg_wdata_i | input | NRES | Debugger port write data |
| dbg_rdata_o | output | NRES | Debugger port read data (combinational, unmasked) |
| evt_i | input | NRES | Debug event pulses, one per resource |
| sw_de_i | input | 1 | Software debug-enable flag from the status word |
| irq_o | output | 1 | Debug interrupt request to exception logic |
| save_done_i | input | 1 | One-cycle pulse: context saved, PC redirected to handler |
| dbgreq_o | output | 1 | Debug-mode entry request |
| dbgack_i | input | 1 | Debugger acknowledge of debug-mode entry |

## Verification
The assertions check, on every cycle:
- that recorded events always appear in status;
- that software status reads never expose hardware-owned bits;
- that a software write leaves the ownership mask untouched;
- that a pending request holds until acknowledged;
- that the request is withheld while context saving is awaited;
- that no request follows when external debug mode is off.

Only the bench's scenarios can show the rest:
- the full routing of each resource as its ownership changes across the three mode cases;
- that an event beats a simultaneous clear;
- the exact two-phase ordering when a software interrupt and a hardware event coincide.

// File: rtl/dbg_share_pkg.sv
package dbg_share_pkg;

    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_ENABLE = 2'd1,
        RA_STATUS = 2'd2,
        RA_OWNER  = 2'd3
    } reg_addr_t;

    localparam int CTRL_BITS = 3;

    typedef struct packed {
        logic share_en;
        logic idm;
        logic edm;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_REQ  = 2'd2
    } seq_state_t;

    function automatic ctrl_t ctrl_sw_merge(input ctrl_t cur, input logic [CTRL_BITS-1:0] wd,
                                            input logic allowed);
        ctrl_t r;
        r = cur;
        if (allowed) r.idm = wd[1];
        return r;
    endfunction

endpackage

// File: rtl/dbg_status_regs.sv
module dbg_status_regs
    import dbg_share_pkg::*;
#(
    parameter int NRES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we_i,
    input  logic [1:0]      sw_addr_i,
    input  logic [NRES-1:0] sw_wdata_i,
    output logic [NRES-1:0] sw_rdata_o,
    input  logic            dbg_we_i,
    input  logic [1:0]      dbg_addr_i,
    input  logic [NRES-1:0] dbg_wdata_i,
    output logic [NRES-1:0] dbg_rdata_o,
    input  logic [NRES-1:0] evt_i,
    output logic [NRES-1:0] status_o,
    output logic [NRES-1:0] hw_own_o,
    output logic [NRES-1:0] evt_hit_o,
    output ctrl_t           ctrl_o
);
    localparam int PADW = NRES - CTRL_BITS;

    ctrl_t           ctrl_q, ctrl_d;
    logic [NRES-1:0] en_q, en_d;
    logic [NRES-1:0] stat_q, stat_d;
    logic [NRES-1:0] own_q, own_d;
    logic [NRES-1:0] hw_own, sw_clr, dbg_clr;
    logic            sw_ctrl_ok;

    always_comb begin
        if (!ctrl_q.edm)          hw_own = '0;
        else if (!ctrl_q.share_en) hw_own = '1;
        else                       hw_own = own_q;
    end

    assign sw_ctrl_ok = !ctrl_q.edm || ctrl_q.share_en;
    assign evt_hit_o  = evt_i & en_q;

    always_comb begin
        sw_clr  = (sw_we_i  && sw_addr_i  == RA_STATUS) ? (sw_wdata_i & ~hw_own) : '0;
        dbg_clr = (dbg_we_i && dbg_addr_i == RA_STATUS) ? dbg_wdata_i : '0;
        stat_d  = evt_hit_o | (stat_q & ~(sw_clr | dbg_clr));

        ctrl_d = ctrl_q;
        en_d   = en_q;
        own_d  = own_q;
        if (sw_we_i && sw_addr_i == RA_CTRL)
            ctrl_d = ctrl_sw_merge(ctrl_q, sw_wdata_i[CTRL_BITS-1:0], sw_ctrl_ok);
        if (sw_we_i && sw_addr_i == RA_ENABLE)
            en_d = (en_q & hw_own) | (sw_wdata_i & ~hw_own);
        if (dbg_we_i) begin
            unique case (dbg_addr_i)
                RA_CTRL:   ctrl_d = ctrl_t'(dbg_wdata_i[CTRL_BITS-1:0]);
                RA_ENABLE: en_d   = dbg_wdata_i;
                RA_OWNER:  own_d  = dbg_wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= '0;
            stat_q <= '0;
            own_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            en_q   <= en_d;
            stat_q <= stat_d;
            own_q  <= own_d;
        end
    end

    always_comb begin
        unique case (sw_addr_i)
            RA_CTRL:   sw_rdata_o = {{PADW{1'b0}}, ctrl_q};
            RA_ENABLE: sw_rdata_o = en_q;
            RA_STATUS: sw_rdata_o = stat_q & ~hw_own;
            default:   sw_rdata_o = own_q;
        endcase
        unique case (dbg_addr_i)
            RA_CTRL:   dbg_rdata_o = {{PADW{1'b0}}, ctrl_q};
            RA_ENABLE: dbg_rdata_o = en_q;
            RA_STATUS: dbg_rdata_o = stat_q;
            default:   dbg_rdata_o = own_q;
        endcase
    end

    assign status_o = stat_q;
    assign hw_own_o = hw_own;
    assign ctrl_o   = ctrl_q;

    // R1: an enabled event is always visible in status on the next cycle
    p_evt_recorded_r1: assert property (@(posedge clk) disable iff (rst)
        (|evt_hit_o) |=> ((stat_q & $past(evt_hit_o)) == $past(evt_hit_o)));

    // R7: software status view never exposes hardware-owned bits
    p_sw_view_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_addr_i == RA_STATUS) |-> ((sw_rdata_o & hw_own) == '0));

    // R6: software writes never move the ownership mask or the locked control bits
    p_owner_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_we_i && !dbg_we_i) |=> ($stable(own_q) && $stable(ctrl_q.edm) && $stable(ctrl_q.share_en)));

endmodule

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq
    import dbg_share_pkg::*;
#(
    parameter int NRES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NRES-1:0] status_i,
    input  logic [NRES-1:0] hw_own_i,
    input  logic [NRES-1:0] evt_hit_i,
    input  ctrl_t           ctrl_i,
    input  logic            sw_de_i,
    input  logic            save_done_i,
    input  logic            dbgack_i,
    output logic            irq_o,
    output logic            dbgreq_o
);
    seq_state_t st_q, st_d;
    logic       hw_evt, sw_due, sw_gate;

    assign sw_gate  = sw_de_i && ctrl_i.idm;
    assign irq_o    = sw_gate && (|(status_i & ~hw_own_i));
    assign hw_evt   = |(evt_hit_i & hw_own_i);
    assign sw_due   = sw_gate && ((|(evt_hit_i & ~hw_own_i)) || (|(status_i & ~hw_own_i)));
    assign dbgreq_o = (st_q == SQ_REQ);

    always_comb begin
        st_d = st_q;
        if (!ctrl_i.edm) begin
            st_d = SQ_IDLE;
        end else begin
            unique case (st_q)
                SQ_IDLE: if (hw_evt) st_d = sw_due ? SQ_WAIT : SQ_REQ;
                SQ_WAIT: if (save_done_i) st_d = SQ_REQ;
                SQ_REQ:  if (dbgack_i) st_d = SQ_IDLE;
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    // R4: request holds until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (dbgreq_o && !dbgack_i && ctrl_i.edm) |=> dbgreq_o);

    // R5: no request while the context save is outstanding
    p_wait_save_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_WAIT && !save_done_i) |=> !dbgreq_o);

    // R9: external debug mode off never yields a request next cycle
    p_no_req_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.edm) |=> !dbgreq_o);

    // R3: lone hardware event from idle requests debug mode next cycle
    p_hw_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_IDLE && ctrl_i.edm && hw_evt && !sw_due) |=> dbgreq_o);

endmodule

// File: rtl/dbg_share_ctrl.sv
module dbg_share_ctrl
    import dbg_share_pkg::*;
#(
    parameter int NRES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we_i,
    input  logic [1:0]      sw_addr_i,
    input  logic [NRES-1:0] sw_wdata_i,
    output logic [NRES-1:0] sw_rdata_o,
    input  logic            dbg_we_i,
    input  logic [1:0]      dbg_addr_i,
    input  logic [NRES-1:0] dbg_wdata_i,
    output logic [NRES-1:0] dbg_rdata_o,
    input  logic [NRES-1:0] evt_i,
    input  logic            sw_de_i,
    output logic            irq_o,
    input  logic            save_done_i,
    output logic            dbgreq_o,
    input  logic            dbgack_i
);
    logic [NRES-1:0] status_w, hw_own_w, evt_hit_w;
    ctrl_t           ctrl_w;

    dbg_status_regs #(.NRES(NRES)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .sw_we_i    (sw_we_i),
        .sw_addr_i  (sw_addr_i),
        .sw_wdata_i (sw_wdata_i),
        .sw_rdata_o (sw_rdata_o),
        .dbg_we_i   (dbg_we_i),
        .dbg_addr_i (dbg_addr_i),
        .dbg_wdata_i(dbg_wdata_i),
        .dbg_rdata_o(dbg_rdata_o),
        .evt_i      (evt_i),
        .status_o   (status_w),
        .hw_own_o   (hw_own_w),
        .evt_hit_o  (evt_hit_w),
        .ctrl_o     (ctrl_w)
    );

    dbg_entry_seq #(.NRES(NRES)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .status_i   (status_w),
        .hw_own_i   (hw_own_w),
        .evt_hit_i  (evt_hit_w),
        .ctrl_i     (ctrl_w),
        .sw_de_i    (sw_de_i),
        .save_done_i(save_done_i),
        .dbgack_i   (dbgack_i),
        .irq_o      (irq_o),
        .dbgreq_o   (dbgreq_o)
    );

endmodule

// File: tb/dbg_share_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_share_ctrl_tb_top;
    localparam int NRES = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sw_we = 1'b0, dbg_we = 1'b0;
    logic [1:0]      sw_addr = 2'd0, dbg_addr = 2'd0;
    logic [NRES-1:0] sw_wdata = '0, dbg_wdata = '0, evt = '0;
    logic [NRES-1:0] sw_rdata, dbg_rdata;
    logic            sw_de = 1'b0, save_done = 1'b0, dbgack = 1'b0;
    logic            irq, dbgreq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string           req;
        int              kind;   // 0 sw_rdata, 1 dbg_rdata, 2 irq, 3 dbgreq
        logic [NRES-1:0] exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    dbg_share_ctrl #(.NRES(NRES)) dut_i (
        .clk(clk), .rst(rst),
        .sw_we_i(sw_we), .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata),
        .dbg_we_i(dbg_we), .dbg_addr_i(dbg_addr), .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
        .evt_i(evt), .sw_de_i(sw_de), .irq_o(irq),
        .save_done_i(save_done), .dbgreq_o(dbgreq), .dbgack_i(dbgack)
    );

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [NRES-1:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = sw_rdata;
                1: act = dbg_rdata;
                2: act = {{(NRES-1){1'b0}}, irq};
                default: act = {{(NRES-1){1'b0}}, dbgreq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(string req, int kind, logic [NRES-1:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic exp_sw(string req, logic [1:0] a, logic [NRES-1:0] e);
        sw_addr = a; push(req, 0, e); settle();
    endtask

    task automatic exp_dbg(string req, logic [1:0] a, logic [NRES-1:0] e);
        dbg_addr = a; push(req, 1, e); settle();
    endtask

    task automatic exp_bits(string req, logic i, logic r);
        push(req, 2, {{(NRES-1){1'b0}}, i});
        push(req, 3, {{(NRES-1){1'b0}}, r});
        settle();
    endtask

    task automatic dbg_wr(logic [1:0] a, logic [NRES-1:0] d);
        @(posedge clk); #1 dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(posedge clk); #1 dbg_we = 1'b0;
    endtask

    task automatic sw_wr(logic [1:0] a, logic [NRES-1:0] d);
        @(posedge clk); #1 sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(posedge clk); #1 sw_we = 1'b0;
    endtask

    task automatic fire(logic [NRES-1:0] m);
        @(posedge clk); #1 evt = m;
        @(posedge clk); #1 evt = '0;
    endtask

    task automatic pulse_ack();
        @(posedge clk); #1 dbgack = 1'b1;
        @(posedge clk); #1 dbgack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state
        exp_dbg("R10 reset ctrl", 2'd0, 8'h00);
        exp_dbg("R10 reset status", 2'd2, 8'h00);
        exp_bits("R9 reset outputs", 1'b0, 1'b0);

        // external debug mode off: all software-owned
        dbg_wr(2'd1, 8'hFF);
        sw_de = 1'b1;
        sw_wr(2'd0, 8'h02);
        fire(8'h01);
        exp_bits("R9 R2 sw event irq no req", 1'b1, 1'b0);
        exp_sw("R9 sw sees status", 2'd2, 8'h01);
        sw_de = 1'b0; #1;
        exp_bits("R2 irq gated by sw_de", 1'b0, 1'b0);
        sw_de = 1'b1;
        sw_wr(2'd2, 8'h01);
        exp_dbg("R11 sw w1c", 2'd2, 8'h00);

        // software cannot touch locked fields
        sw_wr(2'd0, 8'h07);
        exp_dbg("R6 edm/share locked", 2'd0, 8'h02);
        sw_wr(2'd3, 8'hFF);
        exp_dbg("R6 owner locked", 2'd3, 8'h00);

        // sharing active, upper half hardware-owned
        dbg_wr(2'd3, 8'hF0);
        dbg_wr(2'd0, 8'h07);
        fire(8'h10);
        exp_bits("R3 hw event requests debug", 1'b0, 1'b1);
        exp_dbg("R10 debugger sees hw status", 2'd2, 8'h10);
        exp_sw("R7 sw status masked", 2'd2, 8'h00);
        repeat (3) @(posedge clk); #1;
        exp_bits("R4 request held", 1'b0, 1'b1);
        pulse_ack();
        exp_bits("R4 request dropped after ack", 1'b0, 1'b0);
        sw_wr(2'd2, 8'hFF);
        exp_dbg("R7 sw clear of hw bit ignored", 2'd2, 8'h10);
        dbg_wr(2'd2, 8'h10);
        exp_dbg("R11 R10 debugger clears", 2'd2, 8'h00);
        sw_wr(2'd1, 8'h00);
        exp_dbg("R7 sw enable write masked", 2'd1, 8'hF0);
        dbg_wr(2'd1, 8'hFF);

        // simultaneous software and hardware events
        fire(8'h11);
        exp_bits("R5 sw first, req withheld", 1'b1, 1'b0);
        repeat (2) @(posedge clk); #1;
        exp_bits("R5 still waiting for save", 1'b1, 1'b0);
        @(posedge clk); #1 save_done = 1'b1;
        @(posedge clk); #1 save_done = 1'b0;
        exp_bits("R5 req after save", 1'b1, 1'b1);
        pulse_ack();
        dbg_wr(2'd2, 8'h11);

        // event recorded with sw_de low
        sw_de = 1'b0;
        fire(8'h01);
        exp_dbg("R1 recorded with sw_de low", 2'd2, 8'h01);
        exp_bits("R1 no irq with sw_de low", 1'b0, 1'b0);
        dbg_wr(2'd2, 8'h01);
        sw_de = 1'b1;

        // event beats a simultaneous clear
        @(posedge clk); #1 evt = 8'h02; dbg_we = 1'b1; dbg_addr = 2'd2; dbg_wdata = 8'h02;
        @(posedge clk); #1 evt = '0; dbg_we = 1'b0;
        exp_dbg("R1 event beats clear", 2'd2, 8'h02);
        dbg_wr(2'd2, 8'h02);

        // edm on, sharing off: everything hardware-owned
        dbg_wr(2'd0, 8'h03);
        fire(8'h01);
        exp_bits("R8 all hw-owned", 1'b0, 1'b1);
        exp_sw("R8 sw sees nothing", 2'd2, 8'h00);
        pulse_ack();
        sw_wr(2'd2, 8'h01);
        exp_dbg("R8 sw clear ignored", 2'd2, 8'h01);
        dbg_wr(2'd2, 8'h01);

        // edm off again: hw-mask bits now software
        dbg_wr(2'd0, 8'h02);
        fire(8'h10);
        exp_bits("R9 no req when edm off", 1'b1, 1'b0);

        settle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule